// File: doc/BRIEF.md
# Memory Fault Status Capture Register

This block keeps a record of the memory-protection faults that a processor core reports. Each fault type arrives as a single-cycle pulse and sets its own sticky flag in an 8-bit status byte. Only a data access violation comes with a usable faulting address. That address is latched into a separate 32-bit register, and a valid flag in the status byte is raised at the same time. An instruction fetch that lands in an execute-never region is reported on its own input. It raises the instruction violation flag whether or not the protection unit is enabled or even present.

Software reaches both registers through a small word-indexed register bus. Reads are combinational. A write to the status word clears every flag whose write-data bit is 1. Software can also drop the address-valid flag on its own. A handler that has taken over from an escalated fault uses this to mark a captured address that may since have been overwritten.

Top module: `mem_fault_capture`

## Requirements
- R1: While rst_n is low at a rising clock edge, the status byte and the fault address register both become 0.
- R2: A data violation pulse sets status bit 1 and loads dacc_addr_i into the fault address register at the same rising edge.
- R3: The address-valid flag, status bit 7, is set at the same edge on which a data violation captures its address.
- R4: An instruction violation pulse or an execute-never fetch pulse sets status bit 0. Neither changes the fault address register or bit 7.
- R5: A stacking fault sets bit 4, an unstacking fault sets bit 3 and a lazy floating-point preservation fault sets bit 5. None of them changes the fault address register or bit 7.
- R6: Every status flag stays set until software clears it. A later fault of a different type does not disturb it.
- R7: Writing the status word clears each flag whose write-data bit is 1 and leaves the flags whose bit is 0 unchanged. Clearing bit 7 leaves the fault address register unchanged.
- R8: Status bits 2 and 6 and read-data bits 31:8 of the status word always read 0, whatever is written.
- R9: When a fault pulse and a software clear of the same flag fall in the same cycle, the flag ends up set.
- R10: Bus word index 0 is the status word and word index 1 is the fault address. A write to word 1 has no effect on either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iacc_fault_i | input | 1 | Instruction access violation pulse from the protection unit |
| xn_fetch_i | input | 1 | Fetch from an execute-never region, independent of protection enable |
| dacc_fault_i | input | 1 | Data access violation pulse |
| dacc_addr_i | input | 32 | Address of the attempted data access |
| stk_fault_i | input | 1 | Fault while stacking on exception entry |
| unstk_fault_i | input | 1 | Fault while unstacking on exception return |
| lazyfp_fault_i | input | 1 | Fault during lazy floating-point state preservation |
| bus_wen_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | Register word index |
| bus_wdata_i | input | 8 | Write data, 1 bits clear status flags |
| bus_rdata_o | output | 32 | Read data of the selected word |

## Verification
The assertions assume that the fault inputs are clean single-cycle pulses and that dacc_addr_i is stable in any cycle where dacc_fault_i is high. The address checks compare against the address sampled in that cycle. The assertions also assume that the status word is addressed only through bus_addr_i with bus_wen_i qualifying the write. The bench drives every input on the falling edge, holds each pulse for exactly one cycle and returns the write strobe low afterwards. It reads only after the rising edge has been applied, so every stimulus stays inside these assumptions.

// File: rtl/mfsc_pkg.sv
// Package: shared layout constants for the memory fault status capture block.
// Assumes an 8-bit status byte. The bit positions are fixed because software decodes them.
package mfsc_pkg;
    localparam int STAT_W  = 8;
    localparam int B_IACC  = 0;
    localparam int B_DACC  = 1;
    localparam int B_UNSTK = 3;
    localparam int B_STK   = 4;
    localparam int B_LAZY  = 5;
    localparam int B_VALID = 7;
    // Bits holding a real flag. Bits 2 and 6 are reserved.
    localparam logic [STAT_W-1:0] IMPL_MASK = 8'b1011_1011;
    localparam int WORD_STAT = 0;
    localparam int WORD_ADDR = 1;
endpackage

// File: rtl/mfsc_flag_bank.sv
// Module: mfsc_flag_bank
// A row of sticky flags with write-one-to-clear behaviour.
// A set request beats a clear request for the same bit.
// Assumes set requests are one-cycle pulses. Reserved positions are tied to 0.
module mfsc_flag_bank
    import mfsc_pkg::*;
#(
    parameter int          WIDTH = STAT_W,
    parameter logic [WIDTH-1:0] MASK = IMPL_MASK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_vec,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (MASK[i]) begin : g_flag
            logic flag_q;
            // Sticky flag: reset to 0, set wins, otherwise clear on write-one.
            always_ff @(posedge clk) begin
                if (!rst_n)          flag_q <= 1'b0;
                else if (set_vec[i]) flag_q <= 1'b1;
                else if (clr_vec[i]) flag_q <= 1'b0;
            end
            assign q[i] = flag_q;
        end else begin : g_rsvd
            // Reserved position: held at zero, requests discarded.
            assign q[i] = set_vec[i] & clr_vec[i] & 1'b0;
        end
    end
endmodule

// File: rtl/mfsc_addr_capture.sv
// Module: mfsc_addr_capture
// Holds the last faulting data address. It loads only on a capture strobe.
// Assumes the address input is valid in the strobe cycle.
module mfsc_addr_capture #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_q
);
    // Address latch: reset to 0, load on strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    addr_q <= '0;
        else if (load) addr_q <= addr_in;
    end
endmodule

// File: rtl/mfsc_bus_if.sv
// Module: mfsc_bus_if
// Decodes register bus writes into status clear requests and selects read data.
// Assumes a combinational read and a single-cycle write strobe.
// The address word is read-only.
module mfsc_bus_if
    import mfsc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int REG_AW = 1
) (
    input  logic              bus_wen,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [STAT_W-1:0] bus_wdata,
    input  logic [STAT_W-1:0] status,
    input  logic [ADDR_W-1:0] fault_addr,
    output logic [STAT_W-1:0] clr_vec,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [REG_AW-1:0] IDX_STAT = REG_AW'(WORD_STAT);
    localparam logic [REG_AW-1:0] IDX_ADDR = REG_AW'(WORD_ADDR);

    // Write decode: only the status word accepts clear requests.
    always_comb begin
        clr_vec = '0;
        if (bus_wen && bus_addr == IDX_STAT) clr_vec = bus_wdata;
    end

    // Read mux: status is zero-extended, the address is returned as is.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == IDX_STAT)      bus_rdata = DATA_W'(status);
        else if (bus_addr == IDX_ADDR) bus_rdata = DATA_W'(fault_addr);
    end
endmodule

// File: rtl/mem_fault_capture.sv
// Module: mem_fault_capture (top)
// Records memory-protection faults in a sticky status byte.
// On a data violation it captures the faulting address and raises the valid flag.
// Assumes one-cycle fault pulses and a synchronous active-low reset.
module mem_fault_capture
    import mfsc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int REG_AW = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iacc_fault_i,
    input  logic              xn_fetch_i,
    input  logic              dacc_fault_i,
    input  logic [ADDR_W-1:0] dacc_addr_i,
    input  logic              stk_fault_i,
    input  logic              unstk_fault_i,
    input  logic              lazyfp_fault_i,
    input  logic              bus_wen_i,
    input  logic [REG_AW-1:0] bus_addr_i,
    input  logic [STAT_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o
);
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] status_q;
    logic [ADDR_W-1:0] fault_addr_q;

    // Set mapping: each fault source raises its flag. A data violation also raises valid.
    always_comb begin
        set_vec          = '0;
        set_vec[B_IACC]  = iacc_fault_i | xn_fetch_i;
        set_vec[B_DACC]  = dacc_fault_i;
        set_vec[B_UNSTK] = unstk_fault_i;
        set_vec[B_STK]   = stk_fault_i;
        set_vec[B_LAZY]  = lazyfp_fault_i;
        set_vec[B_VALID] = dacc_fault_i;
    end

    mfsc_flag_bank #(.WIDTH(STAT_W), .MASK(IMPL_MASK)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .q       (status_q)
    );

    mfsc_addr_capture #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (dacc_fault_i),
        .addr_in (dacc_addr_i),
        .addr_q  (fault_addr_q)
    );

    mfsc_bus_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW)) u_bus (
        .bus_wen    (bus_wen_i),
        .bus_addr   (bus_addr_i),
        .bus_wdata  (bus_wdata_i),
        .status     (status_q),
        .fault_addr (fault_addr_q),
        .clr_vec    (clr_vec),
        .bus_rdata  (bus_rdata_o)
    );
endmodule

// File: rtl/mfsc_checker.sv
// Module: mfsc_checker
// Temporal checks on the fault capture block, bound to the top module.
// Assumes one-cycle fault pulses and a stable address in the strobe cycle.
module mfsc_checker
    import mfsc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int REG_AW = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dacc,
    input logic [ADDR_W-1:0] dacc_addr,
    input logic              stk,
    input logic              wen,
    input logic [REG_AW-1:0] waddr,
    input logic [STAT_W-1:0] wdata,
    input logic [STAT_W-1:0] status,
    input logic [ADDR_W-1:0] fault_addr
);
    logic stat_wr;
    assign stat_wr = wen && (waddr == REG_AW'(WORD_STAT));

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (status == '0 && fault_addr == '0));

    a_r2_dacc_flag: assert property (@(posedge clk) disable iff (!rst_n)
        dacc |=> status[B_DACC]);

    a_r2_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
        dacc |=> fault_addr == $past(dacc_addr));

    a_r3_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
        dacc |=> status[B_VALID]);

    // R4 as well: no other fault source moves the address.
    a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dacc |=> $stable(fault_addr));

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[B_DACC] && !(stat_wr && wdata[B_DACC])) |=> status[B_DACC]);

    a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wdata[B_STK] && !stk) |=> !status[B_STK]);

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        stk |=> status[B_STK]);
endmodule

bind mem_fault_capture mfsc_checker #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dacc       (dacc_fault_i),
    .dacc_addr  (dacc_addr_i),
    .stk        (stk_fault_i),
    .wen        (bus_wen_i),
    .waddr      (bus_addr_i),
    .wdata      (bus_wdata_i),
    .status     (status_q),
    .fault_addr (fault_addr_q)
);

// File: tb/tb_mem_fault_capture.sv
// Directed bench for mem_fault_capture. Each task runs one scenario and checks it.
module tb_mem_fault_capture;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        iacc_fault_i, xn_fetch_i, dacc_fault_i;
    logic [31:0] dacc_addr_i;
    logic        stk_fault_i, unstk_fault_i, lazyfp_fault_i;
    logic        bus_wen_i;
    logic [0:0]  bus_addr_i;
    logic [7:0]  bus_wdata_i;
    logic [31:0] bus_rdata_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mem_fault_capture dut (.*);

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input int idx, output logic [31:0] d);
        bus_addr_i = idx[0];
        #1;
        d = bus_rdata_o;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {iacc_fault_i, xn_fetch_i, dacc_fault_i, stk_fault_i, unstk_fault_i, lazyfp_fault_i} = '0;
        dacc_addr_i = '0; bus_wen_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // mask: {lazy, stk, unstk, dacc, iacc}
    task automatic pulse(input logic [4:0] m, input logic xn, input logic [31:0] a,
                         input logic wen, input logic [7:0] wd, input int widx);
        @(negedge clk);
        iacc_fault_i = m[0]; dacc_fault_i = m[1]; unstk_fault_i = m[2];
        stk_fault_i = m[3]; lazyfp_fault_i = m[4]; xn_fetch_i = xn;
        dacc_addr_i = a; bus_wen_i = wen; bus_wdata_i = wd; bus_addr_i = widx[0];
        @(negedge clk);
        {iacc_fault_i, xn_fetch_i, dacc_fault_i, stk_fault_i, unstk_fault_i, lazyfp_fault_i} = '0;
        bus_wen_i = 1'b0; bus_wdata_i = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        pulse(5'b11111, 1'b0, 32'hFFFF_FFFC, 1'b0, 8'h00, 0);
        do_reset();
        rd(0, d); check("R1 status after reset", d, 32'h0);
        rd(1, d); check("R1 address after reset", d, 32'h0);
    endtask

    task automatic t_dacc();
        logic [31:0] d;
        do_reset();
        pulse(5'b00010, 1'b0, 32'h2000_1234, 1'b0, 8'h00, 0);
        rd(0, d); check("R2 R3 status after data fault", d, 32'h82);
        rd(1, d); check("R2 R10 captured address", d, 32'h2000_1234);
        pulse(5'b00010, 1'b0, 32'hDEAD_BEE0, 1'b0, 8'h00, 0);
        rd(1, d); check("R2 second capture", d, 32'hDEAD_BEE0);
    endtask

    task automatic t_iacc();
        logic [31:0] d;
        do_reset();
        pulse(5'b00001, 1'b0, 32'h1111_1111, 1'b0, 8'h00, 0);
        rd(0, d); check("R4 instruction fault status", d, 32'h01);
        rd(1, d); check("R4 address untouched", d, 32'h0);
        do_reset();
        pulse(5'b00000, 1'b1, 32'h2222_2222, 1'b0, 8'h00, 0);
        rd(0, d); check("R4 execute-never fetch status", d, 32'h01);
        rd(1, d); check("R4 address untouched by xn", d, 32'h0);
    endtask

    task automatic t_stack();
        logic [31:0] d;
        do_reset();
        pulse(5'b00010, 1'b0, 32'hA5A5_0000, 1'b0, 8'h00, 0);
        pulse(5'b01000, 1'b0, 32'h0BAD_0000, 1'b0, 8'h00, 0);
        rd(0, d); check("R5 stacking fault", d, 32'h92);
        pulse(5'b00100, 1'b0, 32'h0BAD_0004, 1'b0, 8'h00, 0);
        rd(0, d); check("R5 unstacking fault", d, 32'h9A);
        pulse(5'b10000, 1'b0, 32'h0BAD_0008, 1'b0, 8'h00, 0);
        rd(0, d); check("R5 lazy fp fault", d, 32'hBA);
        rd(1, d); check("R5 address held", d, 32'hA5A5_0000);
        repeat (5) @(negedge clk);
        rd(0, d); check("R6 flags stay set", d, 32'hBA);
        pulse(5'b00001, 1'b0, 32'h0, 1'b0, 8'h00, 0);
        rd(0, d); check("R6 other flags kept", d, 32'hBB);
        rd(0, d); check("R8 reserved bits zero", d & 32'hFFFF_FF44, 32'h0);
        pulse(5'b00000, 1'b0, 32'h0, 1'b1, 8'h44, 0);
        rd(0, d); check("R8 write to reserved ignored", d, 32'hBB);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        do_reset();
        pulse(5'b01111, 1'b0, 32'h4000_0040, 1'b0, 8'h00, 0);
        pulse(5'b00000, 1'b0, 32'h0, 1'b1, 8'h00, 0);
        rd(0, d); check("R7 write zero no effect", d, 32'h9B);
        pulse(5'b00000, 1'b0, 32'h0, 1'b1, 8'h02, 0);
        rd(0, d); check("R7 clear data flag", d, 32'h99);
        pulse(5'b00000, 1'b0, 32'h0, 1'b1, 8'h80, 0);
        rd(0, d); check("R7 clear valid flag", d, 32'h19);
        rd(1, d); check("R7 address kept after valid clear", d, 32'h4000_0040);
        pulse(5'b00000, 1'b0, 32'h0, 1'b1, 8'hFF, 1);
        rd(0, d); check("R10 write to address word leaves status", d, 32'h19);
        rd(1, d); check("R10 address word read-only", d, 32'h4000_0040);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        do_reset();
        pulse(5'b01000, 1'b0, 32'h0, 1'b0, 8'h00, 0);
        pulse(5'b01000, 1'b0, 32'h0, 1'b1, 8'h10, 0);
        rd(0, d); check("R9 stacking set beats clear", d, 32'h10);
        pulse(5'b00010, 1'b0, 32'h7777_0000, 1'b1, 8'h92, 0);
        rd(0, d); check("R9 data fault beats valid clear", d, 32'h82);
        rd(1, d); check("R9 address captured", d, 32'h7777_0000);
    endtask

    initial begin
        t_reset();
        t_dacc();
        t_iacc();
        t_stack();
        t_w1c();
        t_set_wins();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule